// File: doc/BRIEF.md
# Transmit Path Failure Monitor

This block sits beside a CAN transmitter and watches the transmit-data input, the receive-data line and the bus state. It detects conditions that would lock up the network or damage the driver. A TXD line stuck dominant, TXD shorted to RXD, and an overtemperature indication each latch a local-failure flag and switch the transmitter off. A bus that stays dominant for too long raises the same flag without switching the transmitter off, and the indication goes away as soon as the bus turns recessive. A separate bus-failure flag is qualified over four consecutive transmit cycles in which the analog front end reports a bus short.

All inputs are expected to be synchronised to `clk` already. The two flags feed a status multiplexer outside this block. The transmitter enable goes to the driver stage. All pins are plain level signals with no handshake. Analog short sensing arrives as the digital `bus_short` indication.

Top module: `tx_path_monitor`

## Requirements
- R1: `mode` uses 2'b00 Standby, 2'b01 Listen-only, 2'b10 Normal and 2'b11 Sleep. Low on `txd` or `rxd` means dominant. After reset both flags are low, and `tx_en` is high exactly when `mode` is Normal and no local failure is latched.
- R2: In Normal or Listen-only mode, if `txd` is sampled dominant on `TXD_TO_CYC` consecutive edges, the local-failure latch sets on the next edge and `tx_en` drops. A shorter dominant run has no effect.
- R3: In Normal or Listen-only mode, a TXD-to-RXD short is detected when `txd` and `rxd` are dominant while `bus_dom` is low on `SHORT_CYC` consecutive edges. The latch then sets on the next edge and `tx_en` drops.
- R4: In Normal or Listen-only mode, `overtemp` sampled high sets the latch on that edge, and `tx_en` drops.
- R5: If `bus_dom` is sampled high on `BUS_TO_CYC` consecutive edges, `local_fail` rises while `tx_en` stays unaffected. It falls in the same cycle that `bus_dom` goes low, with no clock edge needed.
- R6: A latched local failure holds across modes. It releases only on an edge that either enters Normal, or samples `rxd` dominant with `txd` recessive in an active mode. In both cases no latching source may be present at that edge.
- R7: In Standby and Sleep modes, none of the detectors react. Stimulus there leaves both flags unchanged.
- R8: In Normal mode, `bus_fail` sets on the TXD dominant-to-recessive edge that completes four consecutive dominant phases in which `bus_short` was seen while `tx_en` was high. A phase without the indication restarts the count.
- R9: `bus_fail` holds when Normal mode is left. It clears on reset and on re-entering Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| mode | input | 2 | Current operating mode |
| txd | input | 1 | Transmit data, low = dominant |
| rxd | input | 1 | Receive data line level, low = dominant |
| bus_dom | input | 1 | Receiver sees bus dominant |
| bus_short | input | 1 | Bus short seen while driving dominant |
| overtemp | input | 1 | Junction overtemperature indication |
| tx_en | output | 1 | Transmitter driver enable |
| local_fail | output | 1 | Local-failure flag (latched sources or bus clamp) |
| bus_fail | output | 1 | Bus-failure flag |

## Verification
The TXD and short timers reach their limit on the Nth dominant edge, and the latch and `tx_en` follow one edge later. The bench therefore holds each stimulus for a swept N, returns the line recessive, and samples two edges later. Overtemperature latches on the edge that samples it. The bus clamp indication is combinational from the timer, so it is checked one nanosecond after `bus_dom` drops, before any edge. `bus_fail` is registered on the edge that samples the recessive TXD level, and it is read one edge after that level is driven. All stimulus is driven and all outputs are sampled on the falling clock edge.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  typedef enum logic [1:0] {
    MODE_STBY   = 2'b00,
    MODE_LISTEN = 2'b01,
    MODE_NORMAL = 2'b10,
    MODE_SLEEP  = 2'b11
  } op_mode_e;
endpackage

// File: rtl/tpm_run_timer.sv
// Counts consecutive cycles with run high; expired while the run reached LIMIT.
module tpm_run_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] CNT_MAX = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!run)           cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CNT_MAX);

  // R2: expiry only follows a sampled run
  p_expire_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> $past(run));
  // R7: a dropped run clears the timer on the next edge
  p_idle_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !expired);
endmodule

// File: rtl/tpm_fail_latch.sv
// Sticky local-failure bit with set priority and a guarded release.
module tpm_fail_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic release_req,
  input  logic sources_quiet,
  output logic latched
);
  always_ff @(posedge clk) begin
    if (!rst_n)                            latched <= 1'b0;
    else if (set_req)                      latched <= 1'b1;
    else if (release_req && sources_quiet) latched <= 1'b0;
  end

  // R6: without a qualified release the failure holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !(release_req && sources_quiet)) |=> latched);
  // R2: a set request always lands
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> latched);
endmodule

// File: rtl/tpm_busfail_qual.sv
// Qualifies a bus short over EDGES consecutive TXD dominant-to-recessive cycles.
module tpm_busfail_qual #(
  parameter int EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_normal,
  input  logic enter_normal,
  input  logic txd,
  input  logic tx_en,
  input  logic bus_short,
  output logic bus_fail
);
  localparam int CW = $clog2(EDGES + 1);
  localparam logic [CW-1:0] LAST = CW'(EDGES - 1);
  localparam logic [CW-1:0] TOP  = CW'(EDGES);

  logic          txd_q;
  logic          seen;
  logic [CW-1:0] cnt;
  logic          rise;

  assign rise = !txd_q && txd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txd_q    <= 1'b1;
      seen     <= 1'b0;
      cnt      <= '0;
      bus_fail <= 1'b0;
    end else begin
      txd_q <= txd;
      if (enter_normal) begin
        seen     <= 1'b0;
        cnt      <= '0;
        bus_fail <= 1'b0;
      end else if (!in_normal) begin
        seen <= 1'b0;
        cnt  <= '0;
      end else if (rise) begin
        seen <= 1'b0;
        if (seen) begin
          if (cnt == LAST) bus_fail <= 1'b1;
          if (cnt != TOP)  cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
        end
      end else if (!txd && tx_en && bus_short) begin
        seen <= 1'b1;
      end
    end
  end

  // R8: the cycle counter never passes the qualification length
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);
  // R8: the flag rises only after a TXD recessive edge
  p_set_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_fail) |-> ($past(txd) && !$past(txd_q)));
  // R9: only entry into Normal clears the flag
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_fail && !enter_normal) |=> bus_fail);
endmodule

// File: rtl/tx_path_monitor.sv
module tx_path_monitor
  import tpm_pkg::*;
#(
  parameter int TXD_TO_CYC = 1000,
  parameter int SHORT_CYC  = 4,
  parameter int BUS_TO_CYC = 1000,
  parameter int FAIL_EDGES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       txd,
  input  logic       rxd,
  input  logic       bus_dom,
  input  logic       bus_short,
  input  logic       overtemp,
  output logic       tx_en,
  output logic       local_fail,
  output logic       bus_fail
);
  localparam int NTMR = 3;
  localparam int T_TXD = 0;
  localparam int T_SHR = 1;
  localparam int T_BUS = 2;

  function automatic int lim_of(input int idx);
    case (idx)
      T_TXD:   return TXD_TO_CYC;
      T_SHR:   return SHORT_CYC;
      default: return BUS_TO_CYC;
    endcase
  endfunction

  op_mode_e   cur_mode, mode_q;
  logic       in_normal, active, enter_normal;
  logic [NTMR-1:0] run, expd;
  logic       lf_latched, clamp_now;
  logic       set_req, release_req, sources_quiet;

  assign cur_mode     = op_mode_e'(mode);
  assign in_normal    = (cur_mode == MODE_NORMAL);
  assign active       = in_normal || (cur_mode == MODE_LISTEN);
  assign enter_normal = in_normal && (mode_q != MODE_NORMAL);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_STBY;
    else        mode_q <= cur_mode;
  end

  assign run[T_TXD] = active && !txd;
  assign run[T_SHR] = active && !txd && !rxd && !bus_dom;
  assign run[T_BUS] = active && bus_dom;

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    tpm_run_timer #(.LIMIT(lim_of(g))) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run[g]),
      .expired (expd[g])
    );
  end

  assign set_req       = active && (expd[T_TXD] || expd[T_SHR] || overtemp);
  assign sources_quiet = !expd[T_TXD] && !expd[T_SHR] && !overtemp;
  assign release_req   = enter_normal || (active && !rxd && txd);

  tpm_fail_latch u_latch (
    .clk           (clk),
    .rst_n         (rst_n),
    .set_req       (set_req),
    .release_req   (release_req),
    .sources_quiet (sources_quiet),
    .latched       (lf_latched)
  );

  assign clamp_now  = active && bus_dom && expd[T_BUS];
  assign local_fail = lf_latched || clamp_now;
  assign tx_en      = in_normal && !lf_latched;

  tpm_busfail_qual #(.EDGES(FAIL_EDGES)) u_bfq (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_normal    (in_normal),
    .enter_normal (enter_normal),
    .txd          (txd),
    .tx_en        (tx_en),
    .bus_short    (bus_short),
    .bus_fail     (bus_fail)
  );

  // R2: an expired TXD timer in Normal turns the driver off next cycle
  p_txto_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_normal && expd[T_TXD]) |=> !tx_en);
  // R4: overtemperature in an active mode shows on the flag next cycle
  p_ot_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && overtemp) |=> local_fail);
  // R5: with the bus clamp the only cause, the driver stays on
  p_clamp_no_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_normal && $past(in_normal) && !set_req && !$past(set_req) && clamp_now
      && $past(tx_en)) |-> tx_en);
endmodule

// File: tb/tx_path_monitor_test.sv
`timescale 1ns/1ps
module tx_path_monitor_test;
  localparam int TTO = 8;
  localparam int STO = 3;
  localparam int BTO = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       txd = 1'b1, rxd = 1'b1, bus_dom = 1'b0, bus_short = 1'b0, overtemp = 1'b0;
  logic       tx_en, local_fail, bus_fail;
  int         total = 0;
  int         bad = 0;

  always #5 clk = ~clk;

  tx_path_monitor #(.TXD_TO_CYC(TTO), .SHORT_CYC(STO), .BUS_TO_CYC(BTO), .FAIL_EDGES(4)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .txd(txd), .rxd(rxd), .bus_dom(bus_dom),
    .bus_short(bus_short), .overtemp(overtemp),
    .tx_en(tx_en), .local_fail(local_fail), .bus_fail(bus_fail)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic rel_by_rxd();
    rxd = 1'b0; tick(1);
    rxd = 1'b1; tick(1);
  endtask

  task automatic dom_cycle(input logic sh);
    txd = 1'b0; bus_short = sh; tick(2);
    txd = 1'b1; bus_short = 1'b0; tick(1);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 reset local_fail", local_fail, 1'b0);
    chk("R1 reset bus_fail", bus_fail, 1'b0);
    chk("R1 reset tx_en standby", tx_en, 1'b0);
    rst_n = 1'b1; tick(1);
    mode = 2'b10; tick(1);
    chk("R1 tx_en in normal", tx_en, 1'b1);

    // R2: sweep of TXD dominant run length
    for (int n = 1; n <= TTO + 2; n++) begin
      txd = 1'b0; tick(n);
      txd = 1'b1; tick(2);
      chk("R2 txd timeout flag", local_fail, n >= TTO);
      chk("R2 txd timeout gate", tx_en, !(n >= TTO));
      rel_by_rxd();
      chk("R6 release by rxd dominant", local_fail, 1'b0);
    end

    // R3: sweep of TXD-to-RXD short duration
    for (int k = 1; k <= STO + 2; k++) begin
      txd = 1'b0; rxd = 1'b0; tick(k);
      txd = 1'b1; rxd = 1'b1; tick(2);
      chk("R3 short flag", local_fail, k >= STO);
      chk("R3 short gate", tx_en, !(k >= STO));
      rel_by_rxd();
      chk("R6 release after short", tx_en, 1'b1);
    end

    // R4 in Listen-only, R6 hold and release on entering Normal
    mode = 2'b01; tick(1);
    overtemp = 1'b1; tick(1);
    overtemp = 1'b0;
    chk("R4 overtemp flag", local_fail, 1'b1);
    tick(5);
    chk("R6 hold without release", local_fail, 1'b1);
    mode = 2'b00; tick(2);
    chk("R6 hold across standby", local_fail, 1'b1);
    mode = 2'b10; tick(1);
    chk("R6 release on entering normal", local_fail, 1'b0);
    chk("R6 tx_en back", tx_en, 1'b1);

    // R6: release blocked while a source persists
    overtemp = 1'b1; rxd = 1'b0; tick(2);
    rxd = 1'b1; overtemp = 1'b0;
    chk("R6 no release with overtemp", local_fail, 1'b1);
    chk("R4 overtemp gate", tx_en, 1'b0);
    rel_by_rxd();
    chk("R6 release once quiet", local_fail, 1'b0);

    // R7: standby ignores all detectors
    mode = 2'b00; tick(1);
    overtemp = 1'b1; txd = 1'b0; rxd = 1'b0; bus_dom = 1'b1; tick(TTO + 4);
    chk("R7 standby flag", local_fail, 1'b0);
    chk("R7 standby tx_en", tx_en, 1'b0);
    overtemp = 1'b0; txd = 1'b1; rxd = 1'b1; bus_dom = 1'b0; tick(1);
    mode = 2'b01; tick(1);
    chk("R7 listen after standby", local_fail, 1'b0);
    mode = 2'b11; tick(1);
    overtemp = 1'b1; tick(2); overtemp = 1'b0;
    mode = 2'b01; tick(1);
    chk("R7 sleep overtemp ignored", local_fail, 1'b0);
    mode = 2'b10; tick(1);
    chk("R1 tx_en normal again", tx_en, 1'b1);

    // R5: bus clamp, non-latching and not gating
    bus_dom = 1'b1; tick(BTO - 1);
    chk("R5 clamp early", local_fail, 1'b0);
    tick(1);
    chk("R5 clamp flag", local_fail, 1'b1);
    chk("R5 clamp keeps tx_en", tx_en, 1'b1);
    tick(3);
    chk("R5 clamp persists", local_fail, 1'b1);
    bus_dom = 1'b0; #1;
    chk("R5 clamp drops at once", local_fail, 1'b0);
    tick(1);
    chk("R5 clamp stays released", local_fail, 1'b0);
    chk("R5 tx_en after clamp", tx_en, 1'b1);

    // R8: four consecutive shorted cycles
    for (int c = 1; c <= 4; c++) begin
      dom_cycle(1'b1);
      chk("R8 bus_fail count", bus_fail, c == 4);
    end
    mode = 2'b01; tick(1);
    chk("R9 bus_fail holds in listen", bus_fail, 1'b1);
    mode = 2'b10; tick(1);
    chk("R9 bus_fail clears on entry", bus_fail, 1'b0);

    // R8: a clean cycle restarts the count
    for (int c = 0; c < 3; c++) dom_cycle(1'b1);
    dom_cycle(1'b0);
    for (int c = 0; c < 3; c++) dom_cycle(1'b1);
    chk("R8 restart after clean cycle", bus_fail, 1'b0);
    dom_cycle(1'b1);
    chk("R8 set after restart", bus_fail, 1'b1);
    chk("R8 no local failure", local_fail, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule